// File: doc/BRIEF.md
# Serial Pin Shift-Out Controller

This block drives an external chain of serial-in/parallel-out shift register chips. It turns a 17-bit output word into three pins: a shift clock, a serial data line and a latch strobe. The strobe moves the contents of the chain onto the chips' parallel outputs.

The shift clock runs at the system clock divided by a programmable ratio. The data line changes a programmable number of system clocks into each bit slot. A mode pin sets the latch polarity, so the block can drive either of two chip conventions. A second mode pin selects the source of the word. The word can come from the stream input, or it can be a snapshot of the pin values produced by separate waveform generators.

A word enters through a valid/ready handshake. The producer holds `in_valid` and `in_data` until it sees `in_ready`. The word is taken on a clock edge where both are high. `in_ready` is low for the whole transfer, so back-pressure lasts until the latch strobe has finished. `busy` is the complement of `in_ready` and serves as the transfer-in-progress flag.

Top module: `sgo_top`

## Requirements
- R1: While reset is asserted and right after it, `sclk` = 0, `sdata` = 0, `busy` = 0 and `in_ready` = 1, and `latch` sits at its idle level.
- R2: A word is accepted only on a clock edge where `in_valid` and `in_ready` are both 1. From the following cycle, `busy` = 1 and `in_ready` = 0 for exactly 17·N + 1 cycles, where N is the divide ratio.
- R3: The `div_sel` values 0, 1, 2 and 3 select N = 4, 8, 16 and 32. Each bit occupies a slot of N cycles. In each slot, `sclk` is low for the first N/2 cycles and high for the last N/2. `sclk` is low whenever the block is idle.
- R4: The 17 bits leave most significant bit first, bit 16 in slot 0 through bit 0 in slot 16.
- R5: With an effective delay D, `sdata` takes the new bit's value in cycle D−1 of that slot, counting the first cycle of the slot as 0. `sdata` keeps its last value while idle.
- R6: `clk_dly` is clamped to give D. A value of 0 gives D = 1, and a value above N/2 gives D = N/2.
- R7: After slot 16, the latch is active for exactly one cycle. Then `busy` falls. With `chip_mode` = 0 the latch is active high and idles low. With `chip_mode` = 1 it is active low and idles high.
- R8: If `flash_mode` = 1 at acceptance, the word shifted is `pwm_bits` and `in_data` is ignored.
- R9: The word, N and D are captured at acceptance. Changes to `in_data`, `pwm_bits`, `flash_mode`, `div_sel` or `clk_dly` during a transfer do not affect it.
- R10: Asserting `in_valid` while `busy` = 1 is ignored. No second transfer starts, and the current one is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle, word can be taken |
| in_data | input | 17 | Word to shift when `flash_mode` = 0 |
| div_sel | input | 2 | Shift clock ratio code (4/8/16/32) |
| clk_dly | input | 5 | Data launch delay, clamped to 1..N/2 |
| chip_mode | input | 1 | Latch polarity: 0 active high, 1 active low |
| flash_mode | input | 1 | 1: shift `pwm_bits` instead of `in_data` |
| pwm_bits | input | 17 | Pin values from the waveform generators |
| sclk | output | 1 | Shift clock to the chain |
| sdata | output | 1 | Serial data to the chain |
| latch | output | 1 | Latch strobe to the chain |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong phase counter or a wrong slot index shows at the pins within one slot. A wrong phase count moves an `sclk` edge or an `sdata` change by whole cycles. A wrong slot index puts the wrong bit on `sdata` at the next launch point. A fault in the end-of-transfer logic shows as a shortened or stretched `busy`, or a misplaced latch pulse, on the very cycle the transfer should end. The reference model in the bench follows the pins cycle by cycle, so any of these faults is reported in the cycle it appears, not at the end of a transfer.

// File: rtl/sgo_pkg.sv
package sgo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } sgo_state_e;
endpackage

// File: rtl/sgo_cfg.sv
// Decodes the ratio code and clamps the launch delay (R3, R6).
module sgo_cfg #(
  parameter int DIV_W = 2,
  parameter int DLY_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DLY_W-1:0] dly,
  output logic [CNT_W-1:0] last_ph,
  output logic [CNT_W-1:0] half,
  output logic [CNT_W-1:0] launch
);
  int unsigned ratio;
  int unsigned hv;
  int unsigned dv;

  always_comb begin
    ratio = 32'd4 << div_sel;
    hv    = ratio >> 1;
    dv    = 32'(dly);
    if (dv == 0) begin
      dv = 1;
    end else if (dv > hv) begin
      dv = hv;
    end
    last_ph = CNT_W'(ratio - 1);
    half    = CNT_W'(hv);
    launch  = CNT_W'(dv - 1);
  end
endmodule

// File: rtl/sgo_seq.sv
// Slot and phase sequencer: shift slots, then one latch cycle.
module sgo_seq
  import sgo_pkg::*;
#(
  parameter int WORD_W = 17,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] last_in,
  input  logic [CNT_W-1:0] half_in,
  input  logic [CNT_W-1:0] launch_in,
  output logic             load,
  output logic [IDX_W-1:0] load_idx,
  output logic             sclk_o,
  output logic             latch_act,
  output logic             busy_o
);
  sgo_state_e       st_q, st_n;
  logic [CNT_W-1:0] ph_q, ph_n;
  logic [IDX_W-1:0] ix_q, ix_n;
  logic [CNT_W-1:0] last_q, last_n;
  logic [CNT_W-1:0] half_q, half_n;
  logic [CNT_W-1:0] lau_q, lau_n;

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    ix_n   = ix_q;
    last_n = last_q;
    half_n = half_q;
    lau_n  = lau_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_SHIFT;
          ph_n   = '0;
          ix_n   = IDX_W'(WORD_W - 1);
          last_n = last_in;
          half_n = half_in;
          lau_n  = launch_in;
        end
      end
      ST_SHIFT: begin
        if (ph_q == last_q) begin
          if (ix_q == '0) begin
            st_n = ST_LATCH;
          end else begin
            ix_n = ix_q - 1'b1;
            ph_n = '0;
          end
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign load     = (st_n == ST_SHIFT) && (ph_n == lau_n);
  assign load_idx = ix_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      ix_q   <= '0;
      last_q <= '0;
      half_q <= '0;
      lau_q  <= '0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      ix_q   <= ix_n;
      last_q <= last_n;
      half_q <= half_n;
      lau_q  <= lau_n;
    end
  end

  assign sclk_o    = (st_q == ST_SHIFT) && (ph_q >= half_q);
  assign latch_act = (st_q == ST_LATCH);
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/sgo_shreg.sv
// Word capture and serial data register.
module sgo_shreg #(
  parameter int WORD_W = 17,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_idx,
  output logic              sdata_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] src;
  logic              sd_q;

  assign src = start ? word_in : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sd_q   <= 1'b0;
    end else begin
      if (start) word_q <= word_in;
      if (load)  sd_q   <= src[load_idx];
    end
  end

  assign sdata_o = sd_q;
endmodule

// File: rtl/sgo_top.sv
module sgo_top #(
  parameter int WORD_W = 17,
  parameter int DIV_W  = 2,
  parameter int DLY_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [DLY_W-1:0]  clk_dly,
  input  logic              chip_mode,
  input  logic              flash_mode,
  input  logic [WORD_W-1:0] pwm_bits,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic              busy
);
  localparam int CNT_W = (1 << DIV_W) + 1;
  localparam int IDX_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  last_c, half_c, launch_c;
  logic              start, load, latch_act, busy_i;
  logic [IDX_W-1:0]  load_idx;
  logic [WORD_W-1:0] word_sel;

  assign in_ready = ~busy_i;
  assign start    = in_valid & in_ready;
  assign word_sel = flash_mode ? pwm_bits : in_data;

  sgo_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) u_cfg (
    .div_sel (div_sel),
    .dly     (clk_dly),
    .last_ph (last_c),
    .half    (half_c),
    .launch  (launch_c)
  );

  sgo_seq #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_in   (last_c),
    .half_in   (half_c),
    .launch_in (launch_c),
    .load      (load),
    .load_idx  (load_idx),
    .sclk_o    (sclk),
    .latch_act (latch_act),
    .busy_o    (busy_i)
  );

  sgo_shreg #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .word_in  (word_sel),
    .load     (load),
    .load_idx (load_idx),
    .sdata_o  (sdata)
  );

  assign latch = latch_act ^ chip_mode;
  assign busy  = busy_i;
endmodule

// File: rtl/sgo_checker.sv
module sgo_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic sclk,
  input logic sdata,
  input logic latch,
  input logic chip_mode
);
  // R2: an accepted word makes the block busy on the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R3: no shift clock while idle
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R3: each transfer begins in the low half of a slot
  assert_sclk_low_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  // R7: the latch is active for a single cycle
  assert_latch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch != chip_mode) && $stable(chip_mode)) |=> (latch == chip_mode));

  // R7: busy ends only right after the latch cycle
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(latch != chip_mode));

  // R5: serial data holds while idle
  assert_sdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sdata));
endmodule

bind sgo_top sgo_checker u_sgo_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .sclk      (sclk),
  .sdata     (sdata),
  .latch     (latch),
  .chip_mode (chip_mode)
);

// File: tb/sgo_top_test.sv
module sgo_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [16:0] in_data = '0;
  logic [1:0]  div_sel = 2'd0;
  logic [4:0]  clk_dly = 5'd1;
  logic        chip_mode = 1'b0;
  logic        flash_mode = 1'b0;
  logic [16:0] pwm_bits = '0;
  logic        sclk, sdata, latch, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference model state
  bit          m_active = 0, m_latch = 0, m_sd = 0;
  int          m_slot = 0, m_phase = 0, m_n = 4, m_d = 1;
  logic [16:0] m_word = '0;

  // monitor state
  bit          prev_busy = 0, prev_sclk = 0;
  int          bcnt = 0, first_hi = -1, lcnt = 0, lpos = -1;
  logic [16:0] rx = '0;

  always #5 clk = ~clk;

  sgo_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .div_sel(div_sel), .clk_dly(clk_dly),
    .chip_mode(chip_mode), .flash_mode(flash_mode), .pwm_bits(pwm_bits),
    .sclk(sclk), .sdata(sdata), .latch(latch), .busy(busy)
  );

  function automatic int clamp_d(int code, int n);
    if (code == 0) return 1;
    if (code > n / 2) return n / 2;
    return code;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Reference model, advanced on each edge; outputs compared 2 ns later.
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_active = 0; m_latch = 0; m_sd = 0;
    end else begin
      if (m_latch) begin
        m_latch = 0;
      end else if (m_active) begin
        m_phase++;
        if (m_phase == m_n) begin
          m_phase = 0;
          m_slot++;
          if (m_slot == 17) begin
            m_active = 0;
            m_latch = 1;
          end
        end
      end else if (in_valid) begin
        m_word   = flash_mode ? pwm_bits : in_data;
        m_n      = 4 << div_sel;
        m_d      = clamp_d(int'(clk_dly), m_n);
        m_active = 1;
        m_slot   = 0;
        m_phase  = 0;
      end
      if (m_active && m_phase == m_d - 1) m_sd = m_word[16 - m_slot];
    end
    #2;
    if (rst_n) begin
      check("R2 busy", int'(busy), int'(m_active | m_latch));
      check("R2 in_ready", int'(in_ready), int'(!(m_active | m_latch)));
      check("R3 sclk", int'(sclk), int'(m_active && m_phase >= m_n / 2));
      check("R5 sdata", int'(sdata), int'(m_sd));
      check("R7 latch", int'(latch), int'(m_latch ^ chip_mode));
    end
    if (busy) begin
      if (!prev_busy) begin
        bcnt = 0; first_hi = -1; rx = '0; lcnt = 0; lpos = -1;
      end
      if (sdata && first_hi < 0) first_hi = bcnt;
      if (sclk && !prev_sclk) rx = {rx[15:0], sdata};
      if (latch != chip_mode) begin
        lcnt++;
        lpos = bcnt;
      end
      bcnt++;
    end
    prev_busy = busy;
    prev_sclk = sclk;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  // Runs one transfer; optionally disturbs inputs while busy (R9, R10).
  task automatic xfer(input logic [16:0] d, input int sel, input int dly,
                      input bit fl, input logic [16:0] pw, input bit disturb);
    int n;
    logic [16:0] exp_w;
    n = 4 << sel;
    exp_w = fl ? pw : d;
    @(negedge clk);
    in_data = d; div_sel = 2'(sel); clk_dly = 5'(dly);
    flash_mode = fl; pwm_bits = pw; in_valid = 1'b1;
    @(negedge clk);
    if (disturb) begin
      in_data = ~d; pwm_bits = ~pw; flash_mode = ~fl;
      div_sel = 2'(sel ^ 1); clk_dly = 5'd31;
    end else begin
      in_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    in_valid = 1'b0; in_data = d; pwm_bits = pw; flash_mode = fl;
    div_sel = 2'(sel); clk_dly = 5'(dly);
    // R4, R8, R9, R10: bits taken at rising sclk equal the captured word
    check(disturb ? "R4 R9 R10 word" : (fl ? "R4 R8 word" : "R4 word"),
          int'(rx), int'(exp_w));
    // R2, R3: busy length is 17*N+1
    check("R2 R3 busy length", bcnt, 17 * n + 1);
    // R7: one latch cycle, placed right after slot 16
    check("R7 latch count", lcnt, 1);
    check("R7 latch position", lpos, 17 * n);
    @(negedge clk);
    check("R10 no restart", int'(busy), 0);
  endtask

  initial begin
    // R1: reset state
    #23;
    check("R1 sclk", int'(sclk), 0);
    check("R1 sdata", int'(sdata), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 latch", int'(latch), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);

    // R5: MSB=1, LSB=0 patterns; first sdata high at cycle D-1
    xfer(17'h1A5A4, 0, 1, 0, '0, 0);
    check("R5 launch d1", first_hi, 0);
    xfer(17'h10002, 1, 3, 0, '0, 0);
    check("R5 launch d3", first_hi, 2);
    // R6: delay 0 clamps to 1, large delay clamps to N/2
    xfer(17'h1FFFE, 2, 0, 0, '0, 0);
    check("R6 clamp low", first_hi, 0);
    xfer(17'h15554, 1, 20, 0, '0, 0);
    check("R6 clamp high", first_hi, 3);
    xfer(17'h10000, 3, 31, 0, '0, 0);
    check("R6 clamp high n32", first_hi, 15);
    // R8: word from waveform generator pins
    xfer(17'h00F0F, 0, 2, 1, 17'h1C3C2, 0);
    // R9, R10: inputs changed and in_valid held while busy
    xfer(17'h12468, 1, 2, 0, 17'h0F0F0, 1);
    // R7: active-low latch convention
    @(negedge clk);
    chip_mode = 1'b1;
    @(negedge clk);
    check("R7 idle level mode1", int'(latch), 1);
    xfer(17'h0ACE0, 0, 2, 0, '0, 0);
    xfer(17'h1337E, 3, 8, 0, '0, 0);
    chip_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule